// File: doc/BRIEF.md
# Precoded Duobinary Line Encoder

This block turns a serial binary stream into a three-level line signal. On each beat where the input strobe is high, one data bit is taken. The bit first passes an optional differential precoder: an XOR with the bit that went to the mapper on the beat before. The result is mapped to a bipolar value of +1 or -1. A single-tap filter then adds the current bipolar value to the previous one. Each output symbol is therefore -2, 0 or +2.

The precoder removes error propagation at the far end. With it, a receiver only needs to tell zero from non-zero: zero means a 1 was sent and ±2 means a 0 was sent. A mode input bypasses the precoder so that plain duobinary can be produced for comparison.

Each symbol is given both as a small signed value and as a 2-bit code. It appears on registered outputs one clock after the beat that produced it.

Top module: `dbn_line_enc`

## Requirements
- R1: On a beat where `bit_vld_i` is high, the symbol presented on the next clock is the sum of that beat's bipolar value and the bipolar value of the previous beat. Its only possible values are -2, 0 and +2.
- R2: The bipolar mapper sends a mapped bit of 0 to -1 and a mapped bit of 1 to +1.
- R3: With `precode_en_i` high, the mapped bit is the data bit XOR the previously mapped bit. A data bit of 1 then yields symbol 0, and a data bit of 0 yields ±2. From reset, data 0 1 1 0 1 0 1 1 1 0 0 0 gives -2 0 0 -2 0 2 0 0 0 -2 -2 -2.
- R4: With `precode_en_i` low, the data bit is mapped directly. From reset, data 0 1 1 0 1 0 1 1 1 0 0 0 gives -2 0 2 0 0 0 0 2 2 0 -2 -2.
- R5: Internal state advances only on beats with `bit_vld_i` high. On other cycles, `sym_val_o` and `sym_code_o` keep their last value.
- R6: `sym_code_o` encodes the symbol as 2'b00 = -2, 2'b01 = 0 and 2'b10 = +2. It always agrees with `sym_val_o`, and 2'b11 never appears.
- R7: `sym_vld_o` equals `bit_vld_i` delayed by exactly one clock.
- R8: A synchronous active-high `rst` clears the precoder state to 0 and sets the delayed bipolar value to -1. It also drives `sym_vld_o` low, `sym_val_o` to 0 and `sym_code_o` to 2'b01, so a first data bit of 0 after reset yields -2.
- R9: The precoder state always holds the last mapped bit, including in bypass beats. When the mode changes mid-stream, the first precoded beat XORs with the bit most recently sent to the mapper.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_vld_i | input | 1 | Data beat strobe |
| bit_i | input | 1 | Serial data bit |
| precode_en_i | input | 1 | 1 = differential precoder in path, 0 = bypass |
| sym_vld_o | output | 1 | Symbol strobe, one clock after the beat |
| sym_code_o | output | 2 | Symbol code: 00 = -2, 01 = 0, 10 = +2 |
| sym_val_o | output | SYM_W | Signed symbol value |

## Verification
The encoder holds two bits of memory: the precoder bit and the previous bipolar value. A wrong value in either one shows on the very next valid symbol. A bad bipolar history moves the output by ±2 on that beat. A bad precoder bit swaps the zero / non-zero pattern. In bypass mode, a bad precoder bit stays hidden until the mode changes. The bench therefore sweeps every 8-bit pattern in both modes, adds idle gaps and mode switches, and predicts every symbol from the arithmetic of the requirements. Any corrupted state then shows within one beat of being used.

// File: rtl/dbn_pkg.sv
package dbn_pkg;

  typedef enum logic [1:0] {
    SYM_NEG2 = 2'b00,
    SYM_ZERO = 2'b01,
    SYM_POS2 = 2'b10
  } sym_code_e;

  // Three-way classification of a signed symbol from its sign and zero flags
  function automatic sym_code_e classify(input logic is_neg, input logic is_zero);
    if (is_zero)     return SYM_ZERO;
    else if (is_neg) return SYM_NEG2;
    else             return SYM_POS2;
  endfunction

endpackage

// File: rtl/dbn_precoder.sv
module dbn_precoder (
  input  logic clk,
  input  logic rst,
  input  logic adv_i,
  input  logic data_i,
  input  logic pre_en_i,
  output logic map_bit_o
);

  logic state_q;

  // differential precoder or straight pass in bypass mode
  always_comb begin
    if (pre_en_i) map_bit_o = data_i ^ state_q;
    else          map_bit_o = data_i;
  end

  // state always tracks the bit handed to the mapper
  always_ff @(posedge clk) begin
    if (rst)        state_q <= 1'b0;
    else if (adv_i) state_q <= map_bit_o;
  end

endmodule

// File: rtl/dbn_bipolar_map.sv
module dbn_bipolar_map #(
  parameter int SYM_W = 3
) (
  input  logic                    bit_i,
  output logic signed [SYM_W-1:0] bip_o
);

  localparam logic signed [SYM_W-1:0] PLUS_ONE  = {{(SYM_W-1){1'b0}}, 1'b1};
  localparam logic signed [SYM_W-1:0] MINUS_ONE = {SYM_W{1'b1}};

  assign bip_o = bit_i ? PLUS_ONE : MINUS_ONE;

endmodule

// File: rtl/dbn_delay_add.sv
module dbn_delay_add
  import dbn_pkg::*;
#(
  parameter int SYM_W = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    adv_i,
  input  logic signed [SYM_W-1:0] bip_i,
  output logic                    vld_o,
  output logic [1:0]              code_o,
  output logic signed [SYM_W-1:0] val_o
);

  localparam logic signed [SYM_W-1:0] MINUS_ONE = {SYM_W{1'b1}};
  localparam logic signed [SYM_W-1:0] ZERO_VAL  = '0;

  logic signed [SYM_W-1:0] prev_q;
  logic signed [SYM_W-1:0] sum;
  sym_code_e               code_d;

  assign sum    = bip_i + prev_q;
  assign code_d = classify(sum[SYM_W-1], (sum == ZERO_VAL));

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= MINUS_ONE;
      vld_o  <= 1'b0;
      code_o <= SYM_ZERO;
      val_o  <= ZERO_VAL;
    end else begin
      vld_o <= adv_i;
      if (adv_i) begin
        prev_q <= bip_i;
        code_o <= code_d;
        val_o  <= sum;
      end
    end
  end

endmodule

// File: rtl/dbn_line_enc.sv
module dbn_line_enc #(
  parameter int SYM_W = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bit_vld_i,
  input  logic                    bit_i,
  input  logic                    precode_en_i,
  output logic                    sym_vld_o,
  output logic [1:0]              sym_code_o,
  output logic signed [SYM_W-1:0] sym_val_o
);

  logic                    map_bit;
  logic signed [SYM_W-1:0] bip;

  dbn_precoder u_pre (
    .clk       (clk),
    .rst       (rst),
    .adv_i     (bit_vld_i),
    .data_i    (bit_i),
    .pre_en_i  (precode_en_i),
    .map_bit_o (map_bit)
  );

  dbn_bipolar_map #(.SYM_W(SYM_W)) u_map (
    .bit_i (map_bit),
    .bip_o (bip)
  );

  dbn_delay_add #(.SYM_W(SYM_W)) u_add (
    .clk    (clk),
    .rst    (rst),
    .adv_i  (bit_vld_i),
    .bip_i  (bip),
    .vld_o  (sym_vld_o),
    .code_o (sym_code_o),
    .val_o  (sym_val_o)
  );

endmodule

// File: rtl/dbn_line_enc_chk.sv
module dbn_line_enc_chk #(
  parameter int SYM_W = 3
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    bit_vld_i,
  input logic                    bit_i,
  input logic                    precode_en_i,
  input logic                    sym_vld_o,
  input logic [1:0]              sym_code_o,
  input logic signed [SYM_W-1:0] sym_val_o
);

  // R6: code never 11 and agrees with the value
  a_r6_code_legal: assert property (@(posedge clk) disable iff (rst)
    sym_code_o != 2'b11);
  a_r6_code_matches: assert property (@(posedge clk) disable iff (rst)
    (sym_code_o == 2'b01) == (sym_val_o == 0));

  // R1: only -2, 0, +2
  a_r1_three_levels: assert property (@(posedge clk) disable iff (rst)
    (sym_val_o == 0) || (sym_val_o == 2) || (sym_val_o == -2));

  // R7: strobe delayed by one clock
  a_r7_vld_rise: assert property (@(posedge clk) disable iff (rst)
    bit_vld_i |=> sym_vld_o);
  a_r7_vld_idle: assert property (@(posedge clk) disable iff (rst)
    !bit_vld_i |=> !sym_vld_o);

  // R5: symbol holds on idle cycles
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    !bit_vld_i |=> ($stable(sym_val_o) && $stable(sym_code_o)));

  // R3: precoded data 1 gives zero, data 0 gives non-zero
  a_r3_one_zero: assert property (@(posedge clk) disable iff (rst)
    (bit_vld_i && precode_en_i && bit_i) |=> (sym_code_o == 2'b01));
  a_r3_zero_peak: assert property (@(posedge clk) disable iff (rst)
    (bit_vld_i && precode_en_i && !bit_i) |=> (sym_code_o != 2'b01));

endmodule

bind dbn_line_enc dbn_line_enc_chk #(.SYM_W(SYM_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .bit_vld_i    (bit_vld_i),
  .bit_i        (bit_i),
  .precode_en_i (precode_en_i),
  .sym_vld_o    (sym_vld_o),
  .sym_code_o   (sym_code_o),
  .sym_val_o    (sym_val_o)
);

// File: tb/dbn_line_enc_test.sv
module dbn_line_enc_test;

  localparam int SYM_W  = 3;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_vld_i = 1'b0;
  logic bit_i = 1'b0;
  logic precode_en_i = 1'b0;
  logic sym_vld_o;
  logic [1:0] sym_code_o;
  logic signed [SYM_W-1:0] sym_val_o;

  int n_run = 0;
  int n_fail = 0;
  int mq, mb, last_y;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  dbn_line_enc #(.SYM_W(SYM_W)) uut (
    .clk(clk), .rst(rst), .bit_vld_i(bit_vld_i), .bit_i(bit_i),
    .precode_en_i(precode_en_i), .sym_vld_o(sym_vld_o),
    .sym_code_o(sym_code_o), .sym_val_o(sym_val_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int code_of(input int y);
    if (y < 0) return 0;
    if (y == 0) return 1;
    return 2;
  endfunction

  task automatic do_reset();
    rst = 1'b1; bit_vld_i = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    mq = 0; mb = -1; last_y = 0;
  endtask

  // one clock: drive, wait for the edge, check the registered result
  task automatic beat(input logic v, input logic b, input logic m);
    int p, bp, y;
    bit_vld_i = v; bit_i = b; precode_en_i = m;
    @(negedge clk);
    if (v) begin
      p  = m ? (int'(b) ^ mq) : int'(b);    // R3 / R4 / R9
      bp = (p != 0) ? 1 : -1;               // R2
      y  = bp + mb;                         // R1
      mq = p; mb = bp; last_y = y;
      chk(sym_vld_o == 1'b1, "R7", int'(sym_vld_o), 1);
      chk(int'(sym_val_o) == y, m ? "R3" : "R4", int'(sym_val_o), y);
      chk(int'(sym_code_o) == code_of(y), "R6", int'(sym_code_o), code_of(y));
      if (m) chk((b == 1'b1) == (y == 0), "R3", int'(sym_val_o), b ? 0 : 2);
    end else begin
      chk(sym_vld_o == 1'b0, "R7", int'(sym_vld_o), 0);
      chk(int'(sym_val_o) == last_y, "R5", int'(sym_val_o), last_y);
    end
  endtask

  localparam logic [11:0] VEC_BITS = 12'b0110_1011_1000;
  localparam int PRE_EXP [12] = '{-2, 0, 0, -2, 0, 2, 0, 0, 0, -2, -2, -2};
  localparam int BYP_EXP [12] = '{-2, 0, 2, 0, 0, 0, 0, 2, 2, 0, -2, -2};

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    do_reset();
    // R8: reset state at the ports
    chk(sym_vld_o == 1'b0, "R8", int'(sym_vld_o), 0);
    chk(int'(sym_val_o) == 0, "R8", int'(sym_val_o), 0);
    chk(sym_code_o == 2'b01, "R8", int'(sym_code_o), 1);
    beat(1'b1, 1'b0, 1'b1);
    chk(int'(sym_val_o) == -2, "R8", int'(sym_val_o), -2);

    // fixed sequences, precoded then bypassed (R3, R4, R2)
    for (int m = 1; m >= 0; m--) begin
      do_reset();
      for (int i = 0; i < 12; i++) begin
        beat(1'b1, VEC_BITS[11-i], m[0]);
        if (m == 1) chk(int'(sym_val_o) == PRE_EXP[i], "R3", int'(sym_val_o), PRE_EXP[i]);
        else        chk(int'(sym_val_o) == BYP_EXP[i], "R4", int'(sym_val_o), BYP_EXP[i]);
      end
    end

    // exhaustive 8-bit sweep in both modes, with idle gaps for odd patterns (R1, R5)
    for (int m = 0; m < 2; m++) begin
      for (int pat = 0; pat < 256; pat++) begin
        do_reset();
        for (int i = 0; i < 8; i++) begin
          beat(1'b1, pat[i], m[0]);
          if (pat[0] && (i == 3)) begin
            beat(1'b0, ~pat[i], m[0]);
            beat(1'b0, pat[i], ~m[0]);
          end
        end
      end
    end

    // long run with mode switches and gaps (R9, R5)
    do_reset();
    lfsr = 16'hACE1;
    for (int k = 0; k < 3000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      beat(lfsr[0] | lfsr[1], lfsr[2], lfsr[5] & lfsr[7]);
    end

    // reset mid-stream restores start state (R8)
    beat(1'b1, 1'b1, 1'b0);
    do_reset();
    chk(int'(sym_val_o) == 0, "R8", int'(sym_val_o), 0);
    beat(1'b1, 1'b0, 1'b0);
    chk(int'(sym_val_o) == -2, "R8", int'(sym_val_o), -2);

    bit_vld_i = 1'b0;
    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule